// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM with Word Collision Flag

This block is a synchronous dual-port memory. Both ports run from one clock. Port A is a wide port that can read and write 16-bit words. Port B is a narrow read-only port that sees the same storage as 4-bit slices, so it has four times as many addresses. Logic that fills a buffer in wide words and drains it in nibbles can use the block without any width conversion of its own.

When both ports touch the same location in one cycle, the result is defined. Reads on both ports return the contents held before the write of that cycle (read-first).

A conflict is judged on physical words, not on equal address values. The narrow address, with its two slice bits dropped, is compared with the wide address. A registered flag reports each cycle in which port A wrote a word that port B was reading.

Top module: `mwram_mixed`

## Requirements
- R1: A port A write (`a_en`=1, `a_we`=1) stores `a_wdata` at `a_addr`. A later port A read of that address returns the word, one clock after the read is issued. `a_we` has no effect while `a_en` is 0.
- R2: In a cycle where port A writes, `a_rdata` on the next clock shows the word held before that write (read-first).
- R3: A port B address selects a word and a slice. Its upper bits (`b_addr >> 2`) select the wide word and its two low bits select the slice. Slice 0 is word bits [3:0], slice 1 is [7:4], slice 2 is [11:8] and slice 3 is [15:12].
- R4: Port B read data appears one clock after the read is issued. Data written through port A reads back unchanged through port B in any later cycle.
- R5: When port B reads a slice of the word that port A writes in the same cycle, `b_rdata` returns the slice of the contents held before the write.
- R6: `collide` is 1 in the cycle after any cycle with all three of the following:
  - port A wrote;
  - port B was enabled;
  - `b_addr >> 2` equalled `a_addr`.

  Plain equality of the two address values does not count as a collision.
- R7: `collide` is 0 after any cycle in which port A did not write or port B was not enabled. This includes a port A read of the same word that port B reads.
- R8: While a port's enable is 0, that port's read data holds its previous value.
- R9: A synchronous active-high reset clears `a_rdata`, `b_rdata` and `collide` to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write select (qualified by a_en) |
| a_addr | input | AW (8) | Port A word address |
| a_wdata | input | A_WIDTH (16) | Port A write data |
| a_rdata | output | A_WIDTH (16) | Port A read data, read-first |
| b_en | input | 1 | Port B read enable |
| b_addr | input | AW+2 (10) | Port B slice address |
| b_rdata | output | A_WIDTH/4 (4) | Port B read slice |
| collide | output | 1 | Registered flag for a same-word write/read cycle |

## Verification
The hardest case to reach is a collision whose outcome depends on the address mapping. It needs a port A write and a port B read landing on the same physical word in one cycle, and that needs a B address equal to the A address times four plus some slice. The bench reaches it by holding a write on each of several A addresses while sweeping port B across all 1024 narrow addresses. This covers every slice of the written word as well as the address equal in value to `a_addr`, which must not collide. Each step writes a fresh word, so every read-first result is told apart from the newly written data.

// File: rtl/mwram_pkg.sv
package mwram_pkg;
  // Default geometry: wide port word count and width, narrow-to-wide ratio.
  localparam int unsigned MW_DEPTH_DEF = 256;
  localparam int unsigned MW_WIDE_DEF  = 16;
  localparam int unsigned MW_RATIO_DEF = 4;

  // Narrow slice width for a given wide width and ratio.
  function automatic int unsigned narrow_w(input int unsigned wide, input int unsigned ratio);
    return wide / ratio;
  endfunction
endpackage

// File: rtl/mwram_store.sv
module mwram_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDE  = 16,
  parameter int unsigned SELW  = 2,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            a_en,
  input  logic            a_we,
  input  logic [AW-1:0]   a_addr,
  input  logic [WIDE-1:0] a_wdata,
  output logic [WIDE-1:0] a_q,
  input  logic            b_en,
  input  logic [AW-1:0]   b_word,
  output logic [WIDE-1:0] b_q
);
  logic [WIDE-1:0] mem [DEPTH];

  // Write port: no reset so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_addr] <= a_wdata;
  end

  // Port A read register: sampled before this cycle's write lands.
  always_ff @(posedge clk) begin
    if (rst)       a_q <= '0;
    else if (a_en) a_q <= mem[a_addr];
  end

  // Port B reads a whole wide word; slicing happens downstream.
  always_ff @(posedge clk) begin
    if (rst)       b_q <= '0;
    else if (b_en) b_q <= mem[b_word];
  end
endmodule

// File: rtl/mwram_lane.sv
module mwram_lane #(
  parameter int unsigned WIDE  = 16,
  parameter int unsigned RATIO = 4,
  localparam int unsigned NW   = WIDE / RATIO,
  localparam int unsigned SELW = $clog2(RATIO)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            b_en,
  input  logic [SELW-1:0] sel_in,
  input  logic [WIDE-1:0] word_q,
  output logic [NW-1:0]   slice
);
  logic [SELW-1:0] sel_q;
  logic [NW-1:0]   parts [RATIO];

  // The slice index travels alongside the registered word.
  always_ff @(posedge clk) begin
    if (rst)       sel_q <= '0;
    else if (b_en) sel_q <= sel_in;
  end

  for (genvar g = 0; g < RATIO; g++) begin : g_part
    assign parts[g] = word_q[g*NW +: NW];
  end

  assign slice = parts[sel_q];
endmodule

// File: rtl/mwram_clash.sv
module mwram_clash #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] wr_word,
  input  logic [AW-1:0] rd_word,
  output logic          flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= wr && rd && (wr_word == rd_word);
  end
endmodule

// File: rtl/mwram_mixed.sv
module mwram_mixed
  import mwram_pkg::*;
#(
  parameter int unsigned DEPTH   = MW_DEPTH_DEF,
  parameter int unsigned A_WIDTH = MW_WIDE_DEF,
  parameter int unsigned RATIO   = MW_RATIO_DEF,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned SELW   = $clog2(RATIO),
  localparam int unsigned BAW    = AW + SELW,
  localparam int unsigned B_WIDTH = A_WIDTH / RATIO
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_en,
  input  logic               a_we,
  input  logic [AW-1:0]      a_addr,
  input  logic [A_WIDTH-1:0] a_wdata,
  output logic [A_WIDTH-1:0] a_rdata,
  input  logic               b_en,
  input  logic [BAW-1:0]     b_addr,
  output logic [B_WIDTH-1:0] b_rdata,
  output logic               collide
);
  logic [AW-1:0]      b_word;
  logic [SELW-1:0]    b_sel;
  logic [A_WIDTH-1:0] b_word_q;

  assign b_word = b_addr[BAW-1:SELW];
  assign b_sel  = b_addr[SELW-1:0];

  mwram_store #(.DEPTH(DEPTH), .WIDE(A_WIDTH), .SELW(SELW)) u_store (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_q(a_rdata),
    .b_en(b_en), .b_word(b_word), .b_q(b_word_q)
  );

  mwram_lane #(.WIDE(A_WIDTH), .RATIO(RATIO)) u_lane (
    .clk(clk), .rst(rst), .b_en(b_en), .sel_in(b_sel),
    .word_q(b_word_q), .slice(b_rdata)
  );

  mwram_clash #(.AW(AW)) u_clash (
    .clk(clk), .rst(rst),
    .wr(a_en && a_we), .rd(b_en),
    .wr_word(a_addr), .rd_word(b_word),
    .flag(collide)
  );
endmodule

// File: rtl/mwram_chk.sv
module mwram_chk #(
  parameter int unsigned AW   = 8,
  parameter int unsigned WIDE = 16,
  parameter int unsigned NW   = 4,
  parameter int unsigned SELW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            a_en,
  input logic            a_we,
  input logic [AW-1:0]   a_addr,
  input logic [WIDE-1:0] a_wdata,
  input logic [WIDE-1:0] a_rdata,
  input logic            b_en,
  input logic [AW+SELW-1:0] b_addr,
  input logic [NW-1:0]   b_rdata,
  input logic            collide
);
  // R6
  same_word_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (a_en && a_we && b_en && (b_addr[AW+SELW-1:SELW] == a_addr)) |=> collide);

  // R7
  quiet_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!(a_en && a_we) || !b_en) |=> !collide);

  // R8
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_en && !$past(rst)) |=> $stable(a_rdata));

  // R8
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!b_en && !$past(rst)) |=> $stable(b_rdata));

  // R1
  write_readback_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(a_en && a_we) && a_en && !a_we && (a_addr == $past(a_addr)))
      |=> (a_rdata == $past(a_wdata, 2)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (a_rdata == '0 && b_rdata == '0 && !collide));
endmodule

bind mwram_mixed mwram_chk #(.AW(AW), .WIDE(A_WIDTH), .NW(B_WIDTH), .SELW(SELW)) u_chk (
  .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
  .a_wdata(a_wdata), .a_rdata(a_rdata), .b_en(b_en), .b_addr(b_addr),
  .b_rdata(b_rdata), .collide(collide)
);

// File: tb/sim_mwram_mixed.sv
module sim_mwram_mixed;
  localparam int DEPTH = 256;
  localparam int AW = 8;
  localparam int BAW = 10;

  logic clk = 1'b0;
  logic rst;
  logic a_en, a_we;
  logic [AW-1:0] a_addr;
  logic [15:0] a_wdata, a_rdata;
  logic b_en;
  logic [BAW-1:0] b_addr;
  logic [3:0] b_rdata;
  logic collide;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] model [DEPTH];

  always #5 clk = ~clk;

  mwram_mixed u0 (
    .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .b_en(b_en), .b_addr(b_addr),
    .b_rdata(b_rdata), .collide(collide)
  );

  function automatic logic [15:0] pat(input int i, input int k);
    return 16'((i * 16'h3B1D) + (k * 16'h7F4B) + 16'h1234);
  endfunction

  function automatic logic [3:0] nib(input logic [15:0] w, input int s);
    return 4'((w >> (4 * s)) & 16'hF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] hold_a;
    logic [3:0]  hold_b;
    rst = 1'b1; a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0; b_en = 0; b_addr = '0;
    repeat (3) cyc();
    // R9 reset state
    chk("R9 a_rdata", 32'(a_rdata), 0);
    chk("R9 b_rdata", 32'(b_rdata), 0);
    chk("R9 collide", 32'(collide), 0);
    rst = 1'b0;

    // R1 fill every word
    for (int i = 0; i < DEPTH; i++) begin
      a_en = 1; a_we = 1; a_addr = AW'(i); a_wdata = pat(i, 0);
      model[i] = pat(i, 0);
      cyc();
      if (i % 64 == 0) chk("R7 write without B", 32'(collide), 0);
    end
    a_en = 0; a_we = 0;

    // R3 R4 every narrow address
    for (int j = 0; j < 4 * DEPTH; j++) begin
      b_en = 1; b_addr = BAW'(j);
      cyc();
      chk("R3 slice", 32'(b_rdata), 32'(nib(model[j / 4], j % 4)));
    end

    // R1 wide readback; R7 same word read on both ports
    for (int i = 0; i < DEPTH; i++) begin
      a_en = 1; a_we = 0; a_addr = AW'(i);
      b_en = 1; b_addr = BAW'(i * 4 + 1);
      cyc();
      chk("R1 readback", 32'(a_rdata), 32'(model[i]));
      chk("R7 read-read", 32'(collide), 0);
    end

    // R2 R5 R6 collision sweep
    begin
      int alist [4] = '{0, 1, 77, 255};
      for (int q = 0; q < 4; q++) begin
        for (int j = 0; j < 4 * DEPTH; j++) begin
          int a = alist[q];
          logic [15:0] old_a, old_b;
          old_a = model[a];
          old_b = model[j / 4];
          a_en = 1; a_we = 1; a_addr = AW'(a); a_wdata = pat(j, q + 1);
          b_en = 1; b_addr = BAW'(j);
          cyc();
          chk("R2 read-first A", 32'(a_rdata), 32'(old_a));
          if (j / 4 == a) chk("R5 read-first B", 32'(b_rdata), 32'(nib(old_b, j % 4)));
          else            chk("R4 B other word", 32'(b_rdata), 32'(nib(old_b, j % 4)));
          chk("R6 collide", 32'(collide), 32'(j / 4 == a));
          model[a] = pat(j, q + 1);
        end
      end
    end

    // R8 hold with enables low; R1 a_we ignored without a_en
    a_en = 1; a_we = 0; a_addr = 8'd5; b_en = 1; b_addr = 10'd7;
    cyc();
    hold_a = a_rdata; hold_b = b_rdata;
    chk("R8 setup A", 32'(hold_a), 32'(model[5]));
    chk("R8 setup B", 32'(hold_b), 32'(nib(model[1], 3)));
    a_en = 0; a_we = 1; a_addr = 8'd9; a_wdata = 16'hDEAD; b_en = 0; b_addr = 10'd500;
    cyc();
    chk("R8 A held", 32'(a_rdata), 32'(hold_a));
    chk("R8 B held", 32'(b_rdata), 32'(hold_b));
    chk("R7 no enable", 32'(collide), 0);
    cyc();
    chk("R8 A held 2", 32'(a_rdata), 32'(hold_a));
    chk("R8 B held 2", 32'(b_rdata), 32'(hold_b));
    a_en = 1; a_we = 0; a_addr = 8'd9;
    cyc();
    chk("R1 gated write", 32'(a_rdata), 32'(model[9]));

    // R7 write with B disabled on the same word
    a_en = 1; a_we = 1; a_addr = 8'd3; a_wdata = 16'h0F0F; b_en = 0; b_addr = 10'd13;
    model[3] = 16'h0F0F;
    cyc();
    chk("R7 B disabled", 32'(collide), 0);

    // R6 trap: numerically equal addresses, different words
    a_en = 1; a_we = 1; a_addr = 8'd40; a_wdata = 16'h1111; b_en = 1; b_addr = 10'd40;
    model[40] = 16'h1111;
    cyc();
    chk("R6 equal values no collide", 32'(collide), 0);
    a_en = 1; a_we = 1; a_addr = 8'd10; a_wdata = 16'h2222; b_en = 1; b_addr = 10'd42;
    cyc();
    chk("R6 word 10 collide", 32'(collide), 1);

    // R9 mid-run reset
    rst = 1; a_en = 0; a_we = 0; b_en = 0;
    cyc();
    chk("R9 a_rdata mid", 32'(a_rdata), 0);
    chk("R9 b_rdata mid", 32'(b_rdata), 0);
    chk("R9 collide mid", 32'(collide), 0);
    rst = 0;
    cyc();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule